// File: doc/BRIEF.md
# Event Performance Monitor Counters

This block counts events on four 32-bit up-counters for profiling. Each counter picks one of 256 single-cycle event strobes and has its own control word. That word holds a stop bit and freeze conditions that depend on processor state: the privilege level and a mark signal. It also holds a condition-enable bit. A global control word can stop all counters at once, enable the interrupt line, and have the hardware stop everything when an enabled condition appears.

A counter is in its condition state when its top bit is set. Software arms a counter by loading `0x80000000 - N`. The condition then appears after exactly N counted events. The level-sensitive interrupt stays high until software rewrites every enabled counter that is in its condition state. All registers sit on a small synchronous register bus. Reads return data one cycle after the request.

Top module: `evpm_top`

Register map (4-bit word address): 0 global control; 1..4 counters 0..3; 5..8 lane control A 0..3; 9..12 lane control B 0..3. Other addresses read as zero and ignore writes.

Global control bits: bit 0 `stop_all`, bit 1 `irq_on`, bit 2 `stop_on_cond`. Lane control A bits: [7:0] event select, bit 8 `cond_on`, bit 9 freeze while mark clear, bit 10 freeze while mark set, bit 11 freeze in user mode, bit 12 freeze in supervisor mode, bit 13 lane stop. Lane control B is a plain 32-bit read/write word.

## Requirements
- R1: After reset, global control reads 0x1, every lane control A reads 0x3E00, every lane control B and every counter reads 0, and `irq` is low.
- R2: A write on the bus updates the addressed register at that clock edge. A read returns the addressed register's value on `bus_rdata` one cycle after `bus_rd`. Lane control B keeps any 32-bit value written to it.
- R3: An unfrozen counter adds exactly one for each cycle in which the strobe chosen by its event select (bits [7:0]) is high. Other strobes have no effect on it.
- R4: A counter does not change while its lane stop bit (bit 13) is set, or while global `stop_all` (bit 0) is set.
- R5: With bit 12 set, a counter holds while `sup_mode` is 1. With bit 11 set, it holds while `sup_mode` is 0.
- R6: With bit 10 set, a counter holds while `mark` is 1. With bit 9 set, it holds while `mark` is 0.
- R7: `irq` is high exactly when `irq_on` (global bit 1) is set and at least one counter has both `cond_on` (bit 8) and its bit 31 set. It stays high while that is true.
- R8: When `stop_on_cond` (global bit 2) is set and an enabled condition appears, every counter stops in that same cycle: the counter that raised the condition holds exactly 0x80000000. The hardware also sets global bit 0.
- R9: A bus write to a counter loads the written value and takes precedence over an increment in the same cycle. Writing a value below 0x80000000 removes that counter's contribution to `irq`.
- R10: A counter loaded with 0x80000000 - N reaches its condition after exactly N counted events, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| evt_strobe | input | 256 | Per-cycle event strobes |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| mark | input | 1 | Processor mark state |
| irq | output | 1 | Level interrupt |

## Verification
Each counter is driven with strobe bursts on its own event and on nearby events. This separates correct event selection from counting on any strobe. Every freeze qualifier is tried in both states of the processor signal it watches, so a polarity swap shows up as counting in the wrong state. Arming runs stop one event short of the condition and then one past it, which catches off-by-one errors in the condition. With freeze-on-condition on, the exact stop value of 0x80000000 separates a same-cycle freeze from a freeze one cycle late. A bus write coinciding with an active strobe shows whether the load takes priority.

// File: rtl/evpm_pkg.sv
package evpm_pkg;

    localparam int NUM_CTR  = 4;
    localparam int CNT_W    = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SEL_W    = 8;
    localparam int NUM_EVT  = 1 << SEL_W;

    localparam int GCTL_ADDR = 0;
    localparam int CNT_BASE  = 1;
    localparam int CTLA_BASE = CNT_BASE + NUM_CTR;
    localparam int CTLB_BASE = CTLA_BASE + NUM_CTR;

    // Lane control A, packed MSB first: bit 13 down to bit 0
    typedef struct packed {
        logic             lane_stop;     // 13
        logic             frz_sup;       // 12
        logic             frz_usr;       // 11
        logic             frz_mark_set;  // 10
        logic             frz_mark_clr;  // 9
        logic             cond_on;       // 8
        logic [SEL_W-1:0] evt_sel;       // 7:0
    } lane_ctl_t;

    localparam int LCTL_W = $bits(lane_ctl_t);

    // Global control: bit 2 down to bit 0
    typedef struct packed {
        logic stop_on_cond;
        logic irq_on;
        logic stop_all;
    } glob_ctl_t;

    localparam int GCTL_W = $bits(glob_ctl_t);

    localparam lane_ctl_t LANE_CTL_RST = '{lane_stop: 1'b1, frz_sup: 1'b1,
                                           frz_usr: 1'b1, frz_mark_set: 1'b1,
                                           frz_mark_clr: 1'b1, cond_on: 1'b0,
                                           evt_sel: '0};

    localparam glob_ctl_t GLOB_CTL_RST = '{stop_on_cond: 1'b0, irq_on: 1'b0,
                                           stop_all: 1'b1};

    // True when the lane's own qualifiers allow counting this cycle
    function automatic logic lane_qualified(lane_ctl_t c, logic sup, logic mk);
        logic ok;
        ok = !c.lane_stop;
        if (c.frz_sup && sup)  ok = 1'b0;
        if (c.frz_usr && !sup) ok = 1'b0;
        if (mk ? c.frz_mark_set : c.frz_mark_clr) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/evpm_glob.sv
module evpm_glob
    import evpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CTR-1:0] cond_vec,
    output glob_ctl_t          gctl_o,
    output logic               frz_eff,
    output logic               irq
);

    glob_ctl_t gctl_q;
    logic      any_cond;

    assign any_cond = |cond_vec;

    // Hardware freeze on condition dominates a software write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q <= GLOB_CTL_RST;
        end else begin
            if (wr_en)
                gctl_q <= glob_ctl_t'(wdata[GCTL_W-1:0]);
            if (any_cond && gctl_q.stop_on_cond)
                gctl_q.stop_all <= 1'b1;
        end
    end

    // Same-cycle freeze so the raising counter halts at its threshold value
    assign frz_eff = gctl_q.stop_all || (gctl_q.stop_on_cond && any_cond);
    assign irq     = gctl_q.irq_on && any_cond;
    assign gctl_o  = gctl_q;

    assert_cond_sets_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (any_cond && gctl_q.stop_on_cond) |=> gctl_q.stop_all);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gctl_q.irq_on && cond_vec != '0));

endmodule

// File: rtl/evpm_lane.sv
module evpm_lane
    import evpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cnt,
    input  logic               wr_ctl_a,
    input  logic               wr_ctl_b,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               sup_mode,
    input  logic               mark,
    input  logic               frz_glob,
    output logic [CNT_W-1:0]   cnt_o,
    output lane_ctl_t          ctl_a_o,
    output logic [DATA_W-1:0]  ctl_b_o,
    output logic               cond_o
);

    logic [CNT_W-1:0]  cnt_q;
    lane_ctl_t         ctl_a_q;
    logic [DATA_W-1:0] ctl_b_q;
    logic              step;

    assign step = evt_vec[ctl_a_q.evt_sel] && !frz_glob
                  && lane_qualified(ctl_a_q, sup_mode, mark);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ctl_a_q <= LANE_CTL_RST;
            ctl_b_q <= '0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata[CNT_W-1:0];
            else if (step)
                cnt_q <= cnt_q + CNT_W'(1);
            if (wr_ctl_a)
                ctl_a_q <= lane_ctl_t'(wdata[LCTL_W-1:0]);
            if (wr_ctl_b)
                ctl_b_q <= wdata;
        end
    end

    assign cnt_o   = cnt_q;
    assign ctl_a_o = ctl_a_q;
    assign ctl_b_o = ctl_b_q;
    assign cond_o  = ctl_a_q.cond_on && cnt_q[CNT_W-1];

    assert_step_at_most_one_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_glob_freeze_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (frz_glob && !wr_cnt) |=> $stable(cnt_q));

    assert_lane_stop_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_a_q.lane_stop && !wr_cnt) |=> $stable(cnt_q));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_q == $past(wdata[CNT_W-1:0]));

endmodule

// File: rtl/evpm_top.sv
module evpm_top
    import evpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               sup_mode,
    input  logic               mark,
    output logic               irq
);

    logic [NUM_CTR-1:0] cond_vec;
    logic [CNT_W-1:0]   cnt_v   [NUM_CTR];
    lane_ctl_t          ctl_a_v [NUM_CTR];
    logic [DATA_W-1:0]  ctl_b_v [NUM_CTR];
    glob_ctl_t          gctl;
    logic               frz_eff;
    logic               wr_glob;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;

    assign wr_glob = bus_wr && (int'(bus_addr) == GCTL_ADDR);

    evpm_glob u_glob (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_glob),
        .wdata    (bus_wdata),
        .cond_vec (cond_vec),
        .gctl_o   (gctl),
        .frz_eff  (frz_eff),
        .irq      (irq)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
        logic wr_c, wr_a, wr_b;
        assign wr_c = bus_wr && (int'(bus_addr) == CNT_BASE + k);
        assign wr_a = bus_wr && (int'(bus_addr) == CTLA_BASE + k);
        assign wr_b = bus_wr && (int'(bus_addr) == CTLB_BASE + k);

        evpm_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .wr_cnt   (wr_c),
            .wr_ctl_a (wr_a),
            .wr_ctl_b (wr_b),
            .wdata    (bus_wdata),
            .evt_vec  (evt_strobe),
            .sup_mode (sup_mode),
            .mark     (mark),
            .frz_glob (frz_eff),
            .cnt_o    (cnt_v[k]),
            .ctl_a_o  (ctl_a_v[k]),
            .ctl_b_o  (ctl_b_v[k]),
            .cond_o   (cond_vec[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (int'(bus_addr) == GCTL_ADDR)
            rd_mux = {{(DATA_W-GCTL_W){1'b0}}, gctl};
        for (int k = 0; k < NUM_CTR; k++) begin
            if (int'(bus_addr) == CNT_BASE + k)
                rd_mux = cnt_v[k];
            if (int'(bus_addr) == CTLA_BASE + k)
                rd_mux = {{(DATA_W-LCTL_W){1'b0}}, ctl_a_v[k]};
            if (int'(bus_addr) == CTLB_BASE + k)
                rd_mux = ctl_b_v[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    assert_irq_implies_cond_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((cond_vec & {NUM_CTR{gctl.irq_on}}) != '0));

endmodule

// File: tb/evpm_top_tb.sv
module evpm_top_tb;
    import evpm_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               bus_wr, bus_rd;
    logic [ADDR_W-1:0]  bus_addr;
    logic [DATA_W-1:0]  bus_wdata;
    logic [DATA_W-1:0]  bus_rdata;
    logic [NUM_EVT-1:0] evt_strobe;
    logic               sup_mode, mark;
    logic               irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    evpm_top u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_strobe(evt_strobe), .sup_mode(sup_mode), .mark(mark), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(int e, int n);
        evt_strobe[e] = 1'b1;
        repeat (n) @(negedge clk);
        evt_strobe[e] = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 global", GCTL_ADDR, 32'h1);
        rd_chk("R1 ctlA0", CTLA_BASE + 0, 32'h3E00);
        rd_chk("R1 ctlA3", CTLA_BASE + 3, 32'h3E00);
        rd_chk("R1 ctlB2", CTLB_BASE + 2, 32'h0);
        rd_chk("R1 cnt3", CNT_BASE + 3, 32'h0);
    endtask

    task automatic t_select;
        wr(CTLA_BASE + 0, 32'h0005);
        wr(GCTL_ADDR, 32'h0);
        pulse(5, 7);
        pulse(6, 3);
        pulse(4, 2);
        rd_chk("R3 select count", CNT_BASE + 0, 32'd7);
        wr(CTLB_BASE + 1, 32'hA5A5_0001);
        rd_chk("R2 ctlB store", CTLB_BASE + 1, 32'hA5A5_0001);
        rd_chk("R2 ctlA readback", CTLA_BASE + 0, 32'h0005);
    endtask

    task automatic t_stop;
        wr(CTLA_BASE + 0, 32'h2005);
        pulse(5, 4);
        rd_chk("R4 lane stop", CNT_BASE + 0, 32'd7);
        wr(CTLA_BASE + 0, 32'h0005);
        wr(GCTL_ADDR, 32'h1);
        pulse(5, 4);
        rd_chk("R4 stop all", CNT_BASE + 0, 32'd7);
        wr(GCTL_ADDR, 32'h0);
    endtask

    task automatic t_priv;
        wr(CTLA_BASE + 1, 32'h080A);          // freeze in user
        sup_mode = 1'b1; pulse(10, 3);
        sup_mode = 1'b0; pulse(10, 3);
        rd_chk("R5 freeze user", CNT_BASE + 1, 32'd3);
        wr(CTLA_BASE + 1, 32'h100A);          // freeze in supervisor
        sup_mode = 1'b0; pulse(10, 2);
        sup_mode = 1'b1; pulse(10, 2);
        rd_chk("R5 freeze sup", CNT_BASE + 1, 32'd5);
    endtask

    task automatic t_mark;
        wr(CTLA_BASE + 2, 32'h0414);          // freeze while mark set
        mark = 1'b0; pulse(20, 4);
        mark = 1'b1; pulse(20, 4);
        rd_chk("R6 freeze mark set", CNT_BASE + 2, 32'd4);
        wr(CTLA_BASE + 2, 32'h0214);          // freeze while mark clear
        mark = 1'b1; pulse(20, 2);
        mark = 1'b0; pulse(20, 2);
        rd_chk("R6 freeze mark clr", CNT_BASE + 2, 32'd6);
    endtask

    task automatic t_arm;
        wr(GCTL_ADDR, 32'h2);
        wr(CNT_BASE + 3, 32'h8000_0000 - 32'd5);
        wr(CTLA_BASE + 3, 32'h011E);
        pulse(30, 4);
        check("R10 no early cond", {31'b0, irq}, 32'h0);
        pulse(30, 1);
        check("R10 cond at N", {31'b0, irq}, 32'h1);
        rd_chk("R10 threshold", CNT_BASE + 3, 32'h8000_0000);
        pulse(30, 2);
        check("R7 level held", {31'b0, irq}, 32'h1);
        rd_chk("R7 keeps counting", CNT_BASE + 3, 32'h8000_0002);
        wr(CNT_BASE + 3, 32'h0);
        check("R9 ack clears", {31'b0, irq}, 32'h0);
        wr(CNT_BASE + 2, 32'h8000_0000);      // cond_on clear on lane 2
        check("R7 needs cond_on", {31'b0, irq}, 32'h0);
        wr(CNT_BASE + 2, 32'h0);
        wr(GCTL_ADDR, 32'h0);
        wr(CNT_BASE + 3, 32'h8000_0000);
        check("R7 needs irq_on", {31'b0, irq}, 32'h0);
        wr(GCTL_ADDR, 32'h2);
        check("R7 irq on enable", {31'b0, irq}, 32'h1);
        wr(CNT_BASE + 3, 32'h0);
    endtask

    task automatic t_freeze;
        wr(GCTL_ADDR, 32'h6);
        wr(CNT_BASE + 3, 32'h8000_0000 - 32'd2);
        pulse(30, 5);
        rd_chk("R8 exact stop", CNT_BASE + 3, 32'h8000_0000);
        check("R8 irq", {31'b0, irq}, 32'h1);
        rd_chk("R8 stop_all set", GCTL_ADDR, 32'h7);
        pulse(5, 2);
        rd_chk("R8 others frozen", CNT_BASE + 0, 32'd7);
        wr(CNT_BASE + 3, 32'h0);
        wr(GCTL_ADDR, 32'h6);
        pulse(5, 1);
        rd_chk("R8 resume", CNT_BASE + 0, 32'd8);
    endtask

    task automatic t_load_prio;
        evt_strobe[5] = 1'b1;
        wr(CNT_BASE + 0, 32'd100);
        evt_strobe[5] = 1'b0;
        rd_chk("R9 write wins", CNT_BASE + 0, 32'd100);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        evt_strobe = '0; sup_mode = 1'b1; mark = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_select;
        t_stop;
        t_priv;
        t_mark;
        t_arm;
        t_freeze;
        t_load_prio;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule